// File: doc/BRIEF.md
# Migrating Bank-Set Promotion Controller

This block controls one set of a banked cache in which the set's ways live in separate banks, lined up from the bank nearest the controller to the farthest one. A lookup request carries a tag. The controller probes the banks one at a time, nearest first. Each probe costs a fixed base latency plus the bank's distance index. The controller then returns hit or miss, the index of the bank that hit, and the stored data.

The placement of a line changes with use. A hit in any bank other than the nearest swaps the line with its neighbour one step closer. Lines that are used often therefore drift toward the controller and become cheaper to reach. A miss hands the set over to a refill phase. The refill data arrives on a valid/ready input and is installed under the requested tag. Two configuration inputs select where the new line goes and what happens to the line it displaces. A displaced valid line is reported for one cycle on the victim outputs.

Top module: `nuca_set_ctrl`

## Requirements
- R1: After reset every bank is invalid, `req_ready` is 1, and `rsp_valid`, `fill_ready` and `victim_valid` are 0.
- R2: An invalid bank never reports a hit, even when its stored tag equals the requested tag. A lookup of tag 0 in a freshly reset set is therefore a miss.
- R3: The response is a one-cycle pulse. A hit in bank k appears sum over i=0..k of (BASE_LAT+i) cycles after the accepting edge. With the defaults this is 3, 7, 12 or 18 cycles for banks 0 to 3. A miss appears after the full sum (18 cycles) with `rsp_bank` equal to 0.
- R4: A hit in bank k>0 exchanges the contents of banks k and k-1. A following lookup of the same tag hits in bank k-1, and the former occupant of bank k-1 is then found in bank k.
- R5: A hit in bank 0 moves nothing, and `req_ready` is already 1 in the response cycle.
- R6: After a hit in bank k>0, `req_ready` is 0 in the response cycle and in the following cycle, and is 1 again one cycle later.
- R7: After a miss, `fill_ready` is 1 and `req_ready` is 0 from the response cycle until a refill beat is accepted. `req_ready` and `fill_ready` are never both 1.
- R8: With `cfg_near_ins`=0, the refill line is written to the farthest bank and the old occupant of that bank is the victim. `cfg_keep_victim` has no effect in this mode.
- R9: With `cfg_near_ins`=1 and `cfg_keep_victim`=1, each line moves one bank farther, the refill line enters bank 0, and the line that was in the farthest bank is the victim.
- R10: With `cfg_near_ins`=1 and `cfg_keep_victim`=0, the refill line replaces bank 0, the old bank 0 line is the victim, and every other bank is left unchanged.
- R11: `victim_valid` pulses for one cycle, the cycle after the refill beat is accepted, and only when the displaced line was valid. `victim_tag` and `victim_data` carry that line.
- R12: On a hit, `rsp_data` equals the data that was installed with that tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_near_ins | input | 1 | 1: install refill at the nearest bank; 0: at the farthest bank |
| cfg_keep_victim | input | 1 | With near install: 1 shifts lines farther, 0 drops bank 0's line |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Controller idle and able to take a lookup |
| req_tag | input | TAG_W | Tag to look up |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | 1 on hit, 0 on miss |
| rsp_bank | output | clog2(NBANK) | Bank that hit (0 on miss) |
| rsp_data | output | DATA_W | Data of the hit line |
| fill_valid | input | 1 | Refill beat present |
| fill_ready | output | 1 | Controller waiting for refill after a miss |
| fill_data | input | DATA_W | Refill data |
| victim_valid | output | 1 | One-cycle pulse when a valid line is displaced |
| victim_tag | output | TAG_W | Tag of the displaced line |
| victim_data | output | DATA_W | Data of the displaced line |

## Verification
The hardest state to reach from the ports is the shifted arrangement, in which live lines sit in the middle banks and holes lie behind them. It can only be reached through a sequence of misses, refills and promoting hits.

The stimulus installs one line at the far end and walks it to bank 0 with repeated hits. It adds a second far line, and then refills with near insertion and shifting. That refill pushes the walked line into bank 1 and evicts the far line. Later lookups confirm each resulting position through its response latency and bank index. A final near replacement shows that bank 1 survives while bank 0 is evicted.

// File: rtl/nuca_set_ctrl.sv
module nuca_set_ctrl #(
  parameter int NBANK    = 4,
  parameter int TAG_W    = 8,
  parameter int DATA_W   = 16,
  parameter int BASE_LAT = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_near_ins,
  input  logic                 cfg_keep_victim,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [TAG_W-1:0]     req_tag,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic [$clog2(NBANK)-1:0] rsp_bank,
  output logic [DATA_W-1:0]    rsp_data,
  input  logic                 fill_valid,
  output logic                 fill_ready,
  input  logic [DATA_W-1:0]    fill_data,
  output logic                 victim_valid,
  output logic [TAG_W-1:0]     victim_tag,
  output logic [DATA_W-1:0]    victim_data
);
  localparam int BW = $clog2(NBANK);
  localparam int CW = $clog2(BASE_LAT + NBANK + 1);
  localparam logic [BW-1:0] LAST = BW'(NBANK - 1);

  typedef enum logic [2:0] {S_IDLE, S_PROBE, S_SWAP1, S_SWAP2, S_FILL} st_t;

  st_t                st;
  logic [BW-1:0]      pb;
  logic [CW-1:0]      cnt;
  logic [TAG_W-1:0]   cur_tag;
  logic [TAG_W-1:0]   tag_q  [NBANK];
  logic [DATA_W-1:0]  data_q [NBANK];
  logic [NBANK-1:0]   vld_q;

  wire [CW-1:0] lat_m1     = CW'(BASE_LAT - 1) + CW'(pb);
  wire          probe_done = (st == S_PROBE) && (cnt == lat_m1);
  wire          probe_hit  = vld_q[pb] && (tag_q[pb] == cur_tag);
  wire [BW-1:0] nb         = pb - 1'b1;
  wire          drop_near  = cfg_near_ins && !cfg_keep_victim;
  wire [BW-1:0] vi         = drop_near ? '0 : LAST;
  wire [BW-1:0] wi         = cfg_near_ins ? '0 : LAST;

  assign req_ready  = (st == S_IDLE);
  assign fill_ready = (st == S_FILL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      pb           <= '0;
      cnt          <= '0;
      cur_tag      <= '0;
      vld_q        <= '0;
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_bank     <= '0;
      rsp_data     <= '0;
      victim_valid <= 1'b0;
      victim_tag   <= '0;
      victim_data  <= '0;
      for (int i = 0; i < NBANK; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      rsp_valid    <= 1'b0;
      victim_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          cur_tag <= req_tag;
          pb      <= '0;
          cnt     <= '0;
          st      <= S_PROBE;
        end
        S_PROBE: if (probe_done) begin
          cnt <= '0;
          if (probe_hit) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_bank  <= pb;
            rsp_data  <= data_q[pb];
            st        <= (pb == '0) ? S_IDLE : S_SWAP1;
          end else if (pb == LAST) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b0;
            rsp_bank  <= '0;
            rsp_data  <= '0;
            st        <= S_FILL;
          end else begin
            pb <= pb + 1'b1;
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
        S_SWAP1: st <= S_SWAP2;
        S_SWAP2: begin
          tag_q[pb]  <= tag_q[nb];
          tag_q[nb]  <= tag_q[pb];
          data_q[pb] <= data_q[nb];
          data_q[nb] <= data_q[pb];
          vld_q[pb]  <= vld_q[nb];
          vld_q[nb]  <= vld_q[pb];
          st         <= S_IDLE;
        end
        S_FILL: if (fill_valid) begin
          victim_valid <= vld_q[vi];
          victim_tag   <= tag_q[vi];
          victim_data  <= data_q[vi];
          if (cfg_near_ins && cfg_keep_victim) begin
            for (int i = 1; i < NBANK; i++) begin
              tag_q[i]  <= tag_q[i-1];
              data_q[i] <= data_q[i-1];
              vld_q[i]  <= vld_q[i-1];
            end
          end
          tag_q[wi]  <= cur_tag;
          data_q[wi] <= fill_data;
          vld_q[wi]  <= 1'b1;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nuca_set_ctrl_chk.sv
module nuca_set_ctrl_chk #(
  parameter int NBANK    = 4,
  parameter int BASE_LAT = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     rsp_valid,
  input logic                     rsp_hit,
  input logic [$clog2(NBANK)-1:0] rsp_bank,
  input logic                     fill_valid,
  input logic                     fill_ready,
  input logic                     victim_valid
);
  logic [15:0] lat_cnt;

  function automatic int exp_lat(int k);
    int s = 0;
    for (int i = 0; i <= k; i++) s += BASE_LAT + i;
    return s;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lat_cnt <= '0;
    else if (req_valid && req_ready) lat_cnt <= '0;
    else lat_cnt <= lat_cnt + 16'd1;

  wire far_hit  = rsp_valid && rsp_hit && (rsp_bank != '0);
  wire near_hit = rsp_valid && rsp_hit && (rsp_bank == '0);
  wire miss     = rsp_valid && !rsp_hit;

  AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (lat_cnt == 16'(exp_lat(int'(rsp_bank))))); // R3
  AST_MISS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> ((lat_cnt == 16'(exp_lat(NBANK-1))) && (rsp_bank == '0))); // R3
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R3
  AST_NEAR_HIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    near_hit |-> req_ready); // R5
  AST_PROMOTE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    far_hit |-> !req_ready); // R6
  AST_PROMOTE_STALL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    far_hit |=> !req_ready); // R6
  AST_MISS_TO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (fill_ready && !req_ready)); // R7
  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && fill_ready)); // R7
  AST_VICTIM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> $past(fill_valid && fill_ready)); // R11
  AST_VICTIM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |=> !victim_valid); // R11
endmodule

bind nuca_set_ctrl nuca_set_ctrl_chk #(.NBANK(NBANK), .BASE_LAT(BASE_LAT)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_bank(rsp_bank),
  .fill_valid(fill_valid), .fill_ready(fill_ready), .victim_valid(victim_valid)
);

// File: tb/nuca_set_ctrl_tb_top.sv
module nuca_set_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_near_ins = 1'b0, cfg_keep_victim = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_tag = '0;
  logic        fill_valid = 1'b0;
  logic [15:0] fill_data = '0;
  logic        req_ready, rsp_valid, rsp_hit, fill_ready, victim_valid;
  logic [1:0]  rsp_bank;
  logic [15:0] rsp_data, victim_data;
  logic [7:0]  victim_tag;
  int vecs = 0, errs = 0;

  always #4 clk = ~clk;

  nuca_set_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_near_ins(cfg_near_ins), .cfg_keep_victim(cfg_keep_victim),
    .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_bank(rsp_bank), .rsp_data(rsp_data),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_data(fill_data),
    .victim_valid(victim_valid), .victim_tag(victim_tag), .victim_data(victim_data));

  localparam logic [7:0] TA = 8'h00, TB = 8'h21, TC = 8'h42, TD = 8'h63, TE = 8'h84;

  function automatic logic [15:0] dat(input logic [7:0] t);
    return {t, ~t};
  endfunction

  function automatic int exp_lat(input int k);
    int s = 0;
    for (int i = 0; i <= k; i++) s += 3 + i;
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic look_expect(input logic [7:0] t, input logic ehit, input int ebank, input string req);
    int lat;
    logic r0, r1, r2, f0;
    @(negedge clk);
    req_tag = t;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
    lat = 0;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (rsp_valid) break;
    end
    r0 = req_ready; f0 = fill_ready;
    check({req, " hit"}, 32'(rsp_hit), 32'(ehit));
    check({req, " R3 latency"}, 32'(lat), 32'(exp_lat(ehit ? ebank : 3)));
    if (ehit) begin
      check({req, " bank"}, 32'(rsp_bank), 32'(ebank));
      check({req, " R12 data"}, 32'(rsp_data), 32'(dat(t)));
    end else begin
      check({req, " R3 miss bank"}, 32'(rsp_bank), 32'd0);
    end
    @(negedge clk); r1 = req_ready;
    check({req, " R3 pulse"}, 32'(rsp_valid), 32'd0);
    @(negedge clk); r2 = req_ready;
    if (ehit && ebank != 0) begin
      check({req, " R6 stall0"}, 32'(r0), 32'd0);
      check({req, " R6 stall1"}, 32'(r1), 32'd0);
      check({req, " R6 resume"}, 32'(r2), 32'd1);
    end else if (ehit) begin
      check({req, " R5 ready"}, 32'(r0), 32'd1);
    end else begin
      check({req, " R7 fill_ready"}, 32'(f0), 32'd1);
      check({req, " R7 req_ready"}, 32'(r2), 32'd0);
    end
  endtask

  task automatic fill_expect(input logic [7:0] t, input logic near, input logic keep,
                             input logic evv, input logic [7:0] evt, input string req);
    @(negedge clk);
    cfg_near_ins = near; cfg_keep_victim = keep;
    fill_data = dat(t);
    fill_valid = 1'b1;
    while (!fill_ready) @(negedge clk);
    @(posedge clk);
    #1 fill_valid = 1'b0;
    @(negedge clk);
    check({req, " R11 victim_valid"}, 32'(victim_valid), 32'(evv));
    if (evv) begin
      check({req, " victim tag"}, 32'(victim_tag), 32'(evt));
      check({req, " victim data"}, 32'(victim_data), 32'(dat(evt)));
    end
    check({req, " R7 back to idle"}, 32'(req_ready), 32'd1);
    @(negedge clk);
    check({req, " R11 victim pulse"}, 32'(victim_valid), 32'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 req_ready", 32'(req_ready), 32'd1);
    check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1 fill_ready", 32'(fill_ready), 32'd0);
    check("R1 victim_valid", 32'(victim_valid), 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_empty_miss;
    look_expect(TA, 1'b0, 0, "R2 tag0 on empty set");
    fill_expect(TA, 1'b0, 1'b0, 1'b0, 8'h00, "R8 far install");
  endtask

  task automatic t_walk_in;
    look_expect(TA, 1'b1, 3, "R4 far hit");
    look_expect(TA, 1'b1, 2, "R4 promoted to 2");
    look_expect(TA, 1'b1, 1, "R4 promoted to 1");
    look_expect(TA, 1'b1, 0, "R5 nearest hit");
    look_expect(TA, 1'b1, 0, "R5 no movement");
  endtask

  task automatic t_far_insert;
    look_expect(TB, 1'b0, 0, "R7 miss B");
    fill_expect(TB, 1'b0, 1'b1, 1'b0, 8'h00, "R8 far into empty slot");
    look_expect(TC, 1'b0, 0, "R7 miss C");
    fill_expect(TC, 1'b0, 1'b1, 1'b1, TB, "R8 far evicts B, keep ignored");
  endtask

  task automatic t_near_shift;
    look_expect(TD, 1'b0, 0, "R7 miss D");
    fill_expect(TD, 1'b1, 1'b1, 1'b1, TC, "R9 shift evicts farthest");
    look_expect(TA, 1'b1, 1, "R9 A shifted to bank1");
    look_expect(TD, 1'b1, 1, "R4 D swapped to bank1");
  endtask

  task automatic t_near_drop;
    look_expect(TE, 1'b0, 0, "R7 miss E");
    fill_expect(TE, 1'b1, 1'b0, 1'b1, TD, "R10 bank0 replaced");
    look_expect(TA, 1'b1, 1, "R10 bank1 untouched");
    look_expect(TE, 1'b1, 1, "R4 E swapped to bank1");
    look_expect(TD, 1'b0, 0, "R10 dropped line gone");
    fill_expect(TD, 1'b0, 1'b0, 1'b0, 8'h00, "R11 no victim from empty bank");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_empty_miss();
        t_walk_in();
        t_far_insert();
        t_near_shift();
        t_near_drop();
      end
      begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule